// File: doc/BRIEF.md
# ADC Trigger Postscaler With Offset

This block turns the three compare-event pulses of a PWM time base (events A, B and C) into two single-cycle ADC trigger pulses. Each trigger output has its own three-bit source mask. A compare event that is set in the mask is a qualifying event for that trigger, and all the qualifying sources are ORed together.

The second trigger is that plain OR, registered. The first trigger passes through two extra stages before it fires. An offset stage throws away a programmable number of qualifying events (0 to 31). A postscaler then fires on the first event that gets through and on every (P+1)-th event after it, which gives ratios from 1:1 to 1:32. A synchronous restart input clears both counting stages. A PWM controller raises restart at the start of a new period sequence, so the ADC conversions line up with the same place in the sequence every time.

The configuration fields are plain inputs. The surrounding register logic holds them at zero after reset: no source enabled, ratio 1:1, no offset.

Top module: `adc_trig_postscale`

## Requirements
- R1: While rst_n is low, and in the first cycle after it goes high, both trigger outputs are 0.
- R2: For each trigger, a cycle carries one qualifying event when the bitwise AND of the event vector {evt_c, evt_b, evt_a} (bit 0 = A, bit 1 = B, bit 2 = C) with that trigger's mask is non-zero. Events that arrive together count as one event, and events whose mask bit is 0 are not counted.
- R3: trig2 is 1 in the cycle after a cycle that carries a trigger-2 qualifying event, and 0 otherwise. restart, t1_offset and t1_post have no effect on it.
- R4: When t1_src_en is 0, trig1 stays 0 and the trigger-1 counters keep their values, whatever the events do.
- R5: After reset or restart, the first t1_offset trigger-1 qualifying events are discarded and produce no trig1 pulse.
- R6: With postscale value P = t1_post, counting from 0 the qualifying events after the discarded ones, the events numbered 0, P+1, 2(P+1), … fire trig1 and no others do.
- R7: A cycle with restart high clears the offset and postscale counters and does not count its own event. trig1 is 0 in the next cycle.
- R8: trig1 is a one-cycle pulse in the cycle after the event that fires it. With P ≥ 1 held constant, trig1 is never high in two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| restart | input | 1 | Synchronous clear of the trigger-1 counters |
| evt_a | input | 1 | Compare event A pulse |
| evt_b | input | 1 | Compare event B pulse |
| evt_c | input | 1 | Compare event C pulse |
| t1_src_en | input | 3 | Trigger-1 source mask (bit 0 A, bit 1 B, bit 2 C) |
| t1_offset | input | 5 | Trigger-1 events to discard after restart |
| t1_post | input | 5 | Trigger-1 postscale value P, ratio 1:(P+1) |
| t2_src_en | input | 3 | Trigger-2 source mask (bit 0 A, bit 1 B, bit 2 C) |
| trig1 | output | 1 | Trigger-1 pulse |
| trig2 | output | 1 | Trigger-2 pulse |

## Verification
The bench steps through every offset from 0 to 31 combined with every postscale value from 0 to 31. It feeds back-to-back events that mix simultaneous sources with masked-off sources. It computes the fire positions arithmetically from a running count of qualifying events. An off-by-one in the offset compare shows up as a first pulse one event early or late. A wrong postscaler wrap shows up as the wrong spacing at 1:1 or at 1:32. If simultaneous events were counted separately, the phase would slip after every combined event. Separate tests drive events with an empty trigger-1 mask and then enable it. They also raise restart in the same cycle as an event, in the middle of a sequence. A design that advanced its counters on masked events, or counted the event of the restart cycle, would then fire at the wrong place in the new sequence.

// File: rtl/adc_trig_pkg.sv
// Package: shared sizing for the ADC trigger block.
// Assumes three compare sources and 5-bit offset/postscale fields.
package adc_trig_pkg;
    localparam int unsigned SRC_N  = 3;   // compare sources A, B, C
    localparam int unsigned CNT_W  = 5;   // offset / postscale field width
    localparam int unsigned TRIG_N = 2;   // trigger outputs

    typedef logic [SRC_N-1:0] src_vec_t;
    typedef logic [CNT_W-1:0] cnt_t;
endpackage

// File: rtl/evt_qualify.sv
// Module: evt_qualify
// Purpose: reduces a masked compare-event vector to a single qualifying
// strobe. Assumes the events are single-cycle pulses from one clock domain.
module evt_qualify #(
    parameter int unsigned N = 3
) (
    input  logic [N-1:0] evt,
    input  logic [N-1:0] en,
    output logic         hit
);
    // Any enabled event qualifies; coincident events merge into one.
    always_comb begin
        hit = |(evt & en);
    end
endmodule

// File: rtl/offset_postscaler.sv
// Module: offset_postscaler
// Purpose: discards the first OFFSET qualifying events after a clear, then
// fires on the next one and on every (POST+1)-th one after it.
// Assumes a synchronous clear and fields held stable during a sequence.
// The fire output is combinational and is registered by the caller.
module offset_postscaler #(
    parameter int unsigned W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         hit,
    input  logic [W-1:0] offset,
    input  logic [W-1:0] post,
    output logic         fire
);
    logic [W-1:0] skip_cnt;
    logic [W-1:0] div_cnt;
    logic         armed;

    // Offset is used up once the skipped-event count reaches the offset.
    always_comb begin
        armed = (skip_cnt >= offset);
    end

    // Fire on an armed event that lands on a postscale phase of zero.
    always_comb begin
        fire = hit && !clear && armed && (div_cnt == '0);
    end

    // Advance the skip counter, then the postscale phase, on qualifying events.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            skip_cnt <= '0;
            div_cnt  <= '0;
        end else if (hit) begin
            if (!armed) begin
                skip_cnt <= skip_cnt + 1'b1;
            end else if (div_cnt >= post) begin
                div_cnt <= '0;
            end else begin
                div_cnt <= div_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pulse_reg.sv
// Module: pulse_reg
// Purpose: registers a vector of trigger strobes into one-cycle output pulses.
// Assumes strobes are already single-cycle.
module pulse_reg #(
    parameter int unsigned N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    // Capture strobes; reset forces the outputs low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/adc_trig_postscale.sv
// Module: adc_trig_postscale (top)
// Purpose: produces two ADC trigger pulses from compare events A/B/C.
// Trigger 1 goes through an offset and a postscaler; trigger 2 is the plain
// masked OR. Assumes the configuration inputs come from registers that
// reset to zero and change only between restart-delimited sequences.
module adc_trig_postscale
    import adc_trig_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             evt_a,
    input  logic             evt_b,
    input  logic             evt_c,
    input  logic [SRC_N-1:0] t1_src_en,
    input  logic [CNT_W-1:0] t1_offset,
    input  logic [CNT_W-1:0] t1_post,
    input  logic [SRC_N-1:0] t2_src_en,
    output logic             trig1,
    output logic             trig2
);
    src_vec_t              evt_vec;
    src_vec_t              mask [TRIG_N];
    logic     [TRIG_N-1:0] hit;
    logic                  t1_fire;
    logic     [TRIG_N-1:0] strobe;
    logic     [TRIG_N-1:0] pulse;

    // Gather the compare events and per-trigger masks.
    always_comb begin
        evt_vec = {evt_c, evt_b, evt_a};
        mask[0] = t1_src_en;
        mask[1] = t2_src_en;
    end

    // One qualifier per trigger output.
    for (genvar i = 0; i < TRIG_N; i++) begin : g_qual
        evt_qualify #(.N(SRC_N)) u_qual (
            .evt (evt_vec),
            .en  (mask[i]),
            .hit (hit[i])
        );
    end

    offset_postscaler #(.W(CNT_W)) u_t1_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (restart),
        .hit    (hit[0]),
        .offset (t1_offset),
        .post   (t1_post),
        .fire   (t1_fire)
    );

    // Trigger 1 goes through the divider; trigger 2 passes straight.
    always_comb begin
        strobe[0] = t1_fire;
        strobe[1] = hit[1];
    end

    pulse_reg #(.N(TRIG_N)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (strobe),
        .q     (pulse)
    );

    // Drive the ports from the registered pulses.
    always_comb begin
        trig1 = pulse[0];
        trig2 = pulse[1];
    end
endmodule

// File: rtl/adc_trig_postscale_chk.sv
// Module: adc_trig_postscale_chk
// Purpose: port-level properties of adc_trig_postscale, attached by bind.
module adc_trig_postscale_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       restart,
    input logic       evt_a,
    input logic       evt_b,
    input logic       evt_c,
    input logic [2:0] t1_src_en,
    input logic [4:0] t1_post,
    input logic [2:0] t2_src_en,
    input logic       trig1,
    input logic       trig2
);
    // R1: reset keeps both outputs low.
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!trig1 && !trig2));

    // R3: trigger 2 follows its masked OR one cycle later.
    p_t2_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|({evt_c, evt_b, evt_a} & t2_src_en)) |=> trig2);
    p_t2_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(|({evt_c, evt_b, evt_a} & t2_src_en)) |=> !trig2);

    // R4: no enabled trigger-1 source means no trigger-1 pulse.
    p_t1_nosrc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(|({evt_c, evt_b, evt_a} & t1_src_en)) |=> !trig1);

    // R7: restart suppresses trigger 1 in the following cycle.
    p_restart_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !trig1);

    // R8: with a divide ratio above 1:1, pulses never abut.
    p_no_abut_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (trig1 && (t1_post != 5'd0) && $stable(t1_post)) |=> !trig1);
endmodule

bind adc_trig_postscale adc_trig_postscale_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (restart),
    .evt_a     (evt_a),
    .evt_b     (evt_b),
    .evt_c     (evt_c),
    .t1_src_en (t1_src_en),
    .t1_post   (t1_post),
    .t2_src_en (t2_src_en),
    .trig1     (trig1),
    .trig2     (trig2)
);

// File: tb/adc_trig_postscale_test.sv
`timescale 1ns/1ps
module adc_trig_postscale_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       restart;
    logic [2:0] ev;
    logic [2:0] m1;
    logic [2:0] m2;
    logic [4:0] ofs;
    logic [4:0] post;
    logic       trig1;
    logic       trig2;

    int n_chk  = 0;
    int n_fail = 0;
    int qidx   = 0;   // qualifying trigger-1 events since restart
    bit done   = 1'b0;

    always #2 clk = ~clk;

    adc_trig_postscale uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .evt_a     (ev[0]),
        .evt_b     (ev[1]),
        .evt_c     (ev[2]),
        .t1_src_en (m1),
        .t1_offset (ofs),
        .t1_post   (post),
        .t2_src_en (m2),
        .trig1     (trig1),
        .trig2     (trig2)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b (ofs=%0d post=%0d qidx=%0d)",
                     req, act, exp, ofs, post, qidx);
        end
    endtask

    // One cycle of stimulus; checks both outputs one edge later.
    task automatic step(input logic [2:0] e, input logic rs);
        logic q1;
        logic e1;
        logic e2;
        @(negedge clk);
        ev      = e;
        restart = rs;
        q1 = (|(e & m1)) && !rs;
        e1 = q1 && (qidx >= int'(ofs)) &&
             (((qidx - int'(ofs)) % (int'(post) + 1)) == 0);
        e2 = |(e & m2);
        if (rs) qidx = 0;
        else if (q1) qidx++;
        @(posedge clk);
        #1;
        check("R5/R6/R8 trig1", trig1, e1);
        check("R2/R3 trig2", trig2, e2);
    endtask

    initial begin
        rst_n = 1'b0; restart = 1'b0; ev = '0;
        m1 = '0; m2 = '0; ofs = '0; post = '0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 trig1 in reset", trig1, 1'b0);
        check("R1 trig2 in reset", trig2, 1'b0);
        @(negedge clk);
        ev = 3'b111; m1 = 3'b111; m2 = 3'b111;
        @(posedge clk); #1;
        check("R1 trig1 under reset", trig1, 1'b0);
        check("R1 trig2 under reset", trig2, 1'b0);
        @(negedge clk);
        rst_n = 1'b1; ev = '0; m1 = '0; m2 = '0;
        @(posedge clk); #1;
        check("R1 trig1 after release", trig1, 1'b0);
        check("R1 trig2 after release", trig2, 1'b0);

        // R2/R3: trigger 2 over every mask and event combination.
        for (int mm = 0; mm < 8; mm++) begin
            m2 = 3'(mm);
            for (int ee = 0; ee < 8; ee++) step(3'(ee), 1'b0);
        end
        m2 = 3'b000;

        // R4: empty mask, events present, counters must not move.
        ofs = 5'd3; post = 5'd1; m1 = '0;
        step(3'b000, 1'b1);
        for (int k = 0; k < 10; k++) step(3'b111, 1'b0);
        check("R4 no advance while masked", (qidx == 0) ? 1'b1 : 1'b0, 1'b1);
        m1 = 3'b001;
        for (int k = 0; k < 8; k++) step(3'b001, 1'b0);   // first fire at event 3

        // R7: restart mid-sequence with an event in the same cycle.
        ofs = 5'd2; post = 5'd2; m1 = 3'b110;
        step(3'b000, 1'b1);
        for (int k = 0; k < 4; k++) step(3'b010, 1'b0);
        step(3'b110, 1'b1);
        check("R7 restart cycle output", trig1, 1'b0);
        for (int k = 0; k < 9; k++) step(3'b100, 1'b0);

        // R5/R6: full sweep of offset and postscale, mixed event patterns.
        for (int o = 0; o < 32; o++) begin
            for (int p = 0; p < 32; p++) begin
                int target;
                int k;
                ofs  = 5'(o);
                post = 5'(p);
                m1   = (((o + p) % 4) == 3) ? 3'b101 : 3'b111;
                m2   = 3'(o % 8);
                step(3'b000, 1'b1);
                target = o + 2 * (p + 1) + 2;
                k = 0;
                while (qidx < target) begin
                    step(3'((k * 5 + o + p) % 8), 1'b0);
                    k++;
                end
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule